// File: doc/BRIEF.md
# Transactional Read-Write Set Tracker

This block records which lines of a small direct-mapped cache a single hardware transaction has touched. Each line has a speculative read bit, a speculative write bit and a stored tag. A transactional load sets the read bit and a transactional store sets the write bit. An eviction notice or an incoming coherence probe is compared against these bits. When the tracked set would overflow, or when a remote agent conflicts with it, the transaction is aborted. A conflict is always resolved in favour of the remote requester.

A commit clears every speculative bit in one cycle. An abort does the same and also emits a one-cycle mask of the written lines. The data cache uses that mask to throw away the speculative copies of those lines. The block stores no data and does not take part in the coherence protocol. The register checkpoint is kept elsewhere.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset, no transaction is active, `abort_o` is 0, `abort_cause_o` is 2'b00, `drop_mask_o` is 0 and `tracked_cnt_o` is 0.
- R2: An address is split into a line index (its low IDX_W bits) and a tag (the remaining upper bits). During a transaction, a load sets the read bit of its line and a store sets the write bit, and the line's tag is recorded. One cycle later, `tracked_cnt_o` gives the number of lines that have either bit set.
- R3: While no transaction is active, loads, stores, evictions and probes leave every bit unchanged and never raise `abort_o`. A `txn_begin_i` during an active transaction is ignored.
- R4: A probe with write intent whose tag matches a line holding a read bit or a write bit causes a conflict abort, with cause 2'b01.
- R5: A probe with read intent causes a conflict abort (cause 2'b01) only when the matching line holds a write bit. A line that was only read locally does not conflict with a remote read.
- R6: An overflow abort (cause 2'b10) is raised in two cases: an eviction notice names a tracked line with a matching tag, or a local access maps to a tracked line that holds a different tag. An eviction whose tag does not match has no effect.
- R7: A commit ends the transaction and clears all bits in one cycle. `tracked_cnt_o` reads 0 on the next cycle and no abort is raised.
- R8: On an abort, `drop_mask_o` carries the lines whose write bit was set (bit i is line i) for the same single cycle as `abort_o`. All bits are cleared and the transaction ends.
- R9: `abort_cause_o` keeps its value until the next begin that starts a transaction, which resets it to 2'b00.
- R10: A conflict takes priority over every other event in the same cycle. A conflicting probe that arrives together with a commit aborts the transaction. A conflict that coincides with an overflow reports cause 2'b01.
- R11: `abort_o` is a one-cycle pulse in the cycle after the triggering event. After an abort, accesses are ignored until the next begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_begin_i | input | 1 | Start a transaction |
| txn_commit_i | input | 1 | Commit the active transaction |
| acc_valid_i | input | 1 | Local transactional access |
| acc_write_i | input | 1 | Access is a store (1) or load (0) |
| acc_addr_i | input | ADDR_W | Line address of the access |
| evict_valid_i | input | 1 | Eviction notice from the cache |
| evict_addr_i | input | ADDR_W | Line address being evicted |
| probe_valid_i | input | 1 | Incoming coherence probe |
| probe_write_i | input | 1 | Probe has write intent |
| probe_addr_i | input | ADDR_W | Line address of the probe |
| txn_active_o | output | 1 | A transaction is running |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_cause_o | output | 2 | 01 conflict, 10 overflow, 00 none |
| drop_mask_o | output | LINES | Lines to invalidate, valid with abort |
| tracked_cnt_o | output | CNT_W | Lines with a read or write bit set |

## Verification
The bench probes the boundary between the read bit and the write bit. A remote read that hits a read-only line must pass, and a design that also checks read bits for read probes would abort there. It uses aliasing addresses that share an index but carry a different tag. A design that ignores the tag would either miss the overflow on a local access or wrongly abort on an eviction of an unrelated line. Same-cycle collisions of commit with a probe, and of overflow with a conflict, expose a design that gives commit priority or reports the wrong cause. A cause held across the next idle cycles and a drop mask that matches only the written lines catch designs that clear the cause early or drop read-only lines.

// File: rtl/txn_trk_pkg.sv
package txn_trk_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_CONFLICT = 2'b01,
        CAUSE_OVERFLOW = 2'b10
    } abort_cause_e;

    typedef struct packed {
        logic         active;
        logic         abort;
        abort_cause_e cause;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{active: 1'b0, abort: 1'b0, cause: CAUSE_NONE};

endpackage

// File: rtl/trk_line_array.sv
module trk_line_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 4,
    parameter int LINES = 1 << IDX_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_en,
    input  logic [IDX_W-1:0]                set_idx,
    input  logic [TAG_W-1:0]                set_tag,
    input  logic                            set_wr,
    input  logic                            clr_all,
    output logic [LINES-1:0]                rd_bits,
    output logic [LINES-1:0]                wr_bits,
    output logic [LINES-1:0][TAG_W-1:0]     tags
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic             rd_d, rd_q;
        logic             wr_d, wr_q;
        logic [TAG_W-1:0] tag_d, tag_q;
        logic             sel;

        assign sel = set_en && (set_idx == IDX_W'(i));

        always_comb begin
            rd_d  = rd_q;
            wr_d  = wr_q;
            tag_d = tag_q;
            if (clr_all) begin
                rd_d = 1'b0;
                wr_d = 1'b0;
            end else if (sel) begin
                tag_d = set_tag;
                if (set_wr) begin
                    wr_d = 1'b1;
                end else begin
                    rd_d = 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q  <= 1'b0;
                wr_q  <= 1'b0;
                tag_q <= '0;
            end else begin
                rd_q  <= rd_d;
                wr_q  <= wr_d;
                tag_q <= tag_d;
            end
        end

        assign rd_bits[i] = rd_q;
        assign wr_bits[i] = wr_q;
        assign tags[i]    = tag_q;
    end

endmodule

// File: rtl/trk_line_match.sv
module trk_line_match #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 4,
    parameter int LINES = 1 << IDX_W
) (
    input  logic [IDX_W+TAG_W-1:0]      addr,
    input  logic [LINES-1:0]            rd_bits,
    input  logic [LINES-1:0]            wr_bits,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    output logic                        tracked,
    output logic                        tag_eq,
    output logic                        line_rd,
    output logic                        line_wr
);

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    assign idx     = addr[IDX_W-1:0];
    assign tag     = addr[IDX_W+TAG_W-1:IDX_W];
    assign line_rd = rd_bits[idx];
    assign line_wr = wr_bits[idx];
    assign tracked = line_rd || line_wr;
    assign tag_eq  = (tags[idx] == tag);

endmodule

// File: rtl/trk_popcount.sv
module trk_popcount #(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] bits,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
    import txn_trk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - IDX_W,
    parameter int LINES  = 1 << IDX_W,
    parameter int CNT_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_begin_i,
    input  logic              txn_commit_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              evict_valid_i,
    input  logic [ADDR_W-1:0] evict_addr_i,
    input  logic              probe_valid_i,
    input  logic              probe_write_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              txn_active_o,
    output logic              abort_o,
    output logic [1:0]        abort_cause_o,
    output logic [LINES-1:0]  drop_mask_o,
    output logic [CNT_W-1:0]  tracked_cnt_o
);

    ctl_state_t         ctl_d, ctl_q;
    logic [LINES-1:0]   drop_d, drop_q;

    logic [LINES-1:0]             rd_bits, wr_bits;
    logic [LINES-1:0][TAG_W-1:0]  tags;

    logic set_en, clr_all;

    // lookup results: 0 = access, 1 = eviction, 2 = probe
    logic [2:0] lk_tracked, lk_tag_eq, lk_rd, lk_wr;
    logic [2:0][ADDR_W-1:0] lk_addr;

    assign lk_addr[0] = acc_addr_i;
    assign lk_addr[1] = evict_addr_i;
    assign lk_addr[2] = probe_addr_i;

    for (genvar k = 0; k < 3; k++) begin : g_lookup
        trk_line_match #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINES(LINES)) u_match (
            .addr    (lk_addr[k]),
            .rd_bits (rd_bits),
            .wr_bits (wr_bits),
            .tags    (tags),
            .tracked (lk_tracked[k]),
            .tag_eq  (lk_tag_eq[k]),
            .line_rd (lk_rd[k]),
            .line_wr (lk_wr[k])
        );
    end

    logic probe_conflict, evict_overflow, access_overflow;

    always_comb begin
        probe_conflict  = probe_valid_i && lk_tag_eq[2] &&
                          (probe_write_i ? (lk_rd[2] || lk_wr[2]) : lk_wr[2]);
        evict_overflow  = evict_valid_i && lk_tracked[1] && lk_tag_eq[1];
        access_overflow = acc_valid_i && lk_tracked[0] && !lk_tag_eq[0];
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.abort = 1'b0;
        drop_d      = '0;
        set_en      = 1'b0;
        clr_all     = 1'b0;
        if (ctl_q.active) begin
            if (probe_conflict || evict_overflow || access_overflow) begin
                ctl_d.abort  = 1'b1;
                ctl_d.active = 1'b0;
                ctl_d.cause  = probe_conflict ? CAUSE_CONFLICT : CAUSE_OVERFLOW;
                drop_d       = wr_bits;
                clr_all      = 1'b1;
            end else if (txn_commit_i) begin
                ctl_d.active = 1'b0;
                clr_all      = 1'b1;
            end else if (acc_valid_i) begin
                set_en = 1'b1;
            end
        end else if (txn_begin_i) begin
            ctl_d.active = 1'b1;
            ctl_d.cause  = CAUSE_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RESET;
            drop_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            drop_q <= drop_d;
        end
    end

    trk_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINES(LINES)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_idx (acc_addr_i[IDX_W-1:0]),
        .set_tag (acc_addr_i[ADDR_W-1:IDX_W]),
        .set_wr  (acc_write_i),
        .clr_all (clr_all),
        .rd_bits (rd_bits),
        .wr_bits (wr_bits),
        .tags    (tags)
    );

    trk_popcount #(.WIDTH(LINES), .CNT_W(CNT_W)) u_count (
        .bits  (rd_bits | wr_bits),
        .count (tracked_cnt_o)
    );

    assign txn_active_o  = ctl_q.active;
    assign abort_o       = ctl_q.abort;
    assign abort_cause_o = ctl_q.cause;
    assign drop_mask_o   = drop_q;

endmodule

// File: rtl/txn_trk_checker.sv
module txn_trk_checker #(
    parameter int LINES = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txn_begin_i,
    input logic             txn_active_o,
    input logic             abort_o,
    input logic [1:0]       abort_cause_o,
    input logic [LINES-1:0] drop_mask_o,
    input logic [CNT_W-1:0] tracked_cnt_o
);

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o); // R11

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (abort_cause_o == 2'b01 || abort_cause_o == 2'b10)); // R4

    AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_active_o |=> !abort_o); // R3

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_active_o |-> (tracked_cnt_o == '0)); // R7

    AST_DROP_ONLY_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_mask_o != '0) |-> abort_o); // R8

    AST_ABORT_ENDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !txn_active_o); // R8

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_o && !$past(txn_begin_i)) |-> $stable(abort_cause_o)); // R9

endmodule

bind txn_set_tracker txn_trk_checker #(.LINES(LINES), .CNT_W(CNT_W)) u_trk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .txn_begin_i   (txn_begin_i),
    .txn_active_o  (txn_active_o),
    .abort_o       (abort_o),
    .abort_cause_o (abort_cause_o),
    .drop_mask_o   (drop_mask_o),
    .tracked_cnt_o (tracked_cnt_o)
);

// File: tb/test_txn_set_tracker.sv
module test_txn_set_tracker;

    localparam int ADDR_W = 8;
    localparam int IDX_W  = 4;
    localparam int LINES  = 16;
    localparam int CNT_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b, c, av, aw, ev, pv, pw;
    logic [ADDR_W-1:0] aa, ea, pa;
    logic act, abt;
    logic [1:0] cause;
    logic [LINES-1:0] drop;
    logic [CNT_W-1:0] cnt;

    always #5 clk = ~clk;

    txn_set_tracker i_txn_set_tracker (
        .clk(clk), .rst_n(rst_n),
        .txn_begin_i(b), .txn_commit_i(c),
        .acc_valid_i(av), .acc_write_i(aw), .acc_addr_i(aa),
        .evict_valid_i(ev), .evict_addr_i(ea),
        .probe_valid_i(pv), .probe_write_i(pw), .probe_addr_i(pa),
        .txn_active_o(act), .abort_o(abt), .abort_cause_o(cause),
        .drop_mask_o(drop), .tracked_cnt_o(cnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference
    int m_rd[LINES], m_wr[LINES], m_tag[LINES];
    int m_act = 0, m_abt = 0, m_cause = 0;
    int m_drop[$];

    task automatic chk(string req, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int m_count();
        int s = 0;
        for (int i = 0; i < LINES; i++) if (m_rd[i] != 0 || m_wr[i] != 0) s++;
        return s;
    endfunction

    function automatic int m_dropval();
        int v = 0;
        foreach (m_drop[k]) v = v | (1 << m_drop[k]);
        return v;
    endfunction

    task automatic model_step();
        int ai = int'(aa[3:0]), at = int'(aa[7:4]);
        int ei = int'(ea[3:0]), et = int'(ea[7:4]);
        int pi = int'(pa[3:0]), pt = int'(pa[7:4]);
        bit pc, eo, ao;
        m_abt = 0;
        m_drop.delete();
        if (m_act != 0) begin
            pc = pv && m_tag[pi] == pt && (pw ? (m_rd[pi] != 0 || m_wr[pi] != 0) : m_wr[pi] != 0);
            eo = ev && (m_rd[ei] != 0 || m_wr[ei] != 0) && m_tag[ei] == et;
            ao = av && (m_rd[ai] != 0 || m_wr[ai] != 0) && m_tag[ai] != at;
            if (pc || eo || ao) begin
                m_abt = 1;
                m_cause = pc ? 1 : 2;
                for (int i = 0; i < LINES; i++) if (m_wr[i] != 0) m_drop.push_back(i);
                for (int i = 0; i < LINES; i++) begin m_rd[i] = 0; m_wr[i] = 0; end
                m_act = 0;
            end else if (c) begin
                for (int i = 0; i < LINES; i++) begin m_rd[i] = 0; m_wr[i] = 0; end
                m_act = 0;
            end else if (av) begin
                m_tag[ai] = at;
                if (aw) m_wr[ai] = 1; else m_rd[ai] = 1;
            end
        end else if (b) begin
            m_act = 1;
            m_cause = 0;
        end
    endtask

    task automatic clr_in();
        b = 0; c = 0; av = 0; aw = 0; ev = 0; pv = 0; pw = 0;
        aa = '0; ea = '0; pa = '0;
    endtask

    task automatic tick(string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({req, " active"}, int'(act), m_act);
        chk({req, " abort"}, int'(abt), m_abt);
        chk({req, " cause"}, int'(cause), m_cause);
        chk({req, " drop"}, int'(drop), m_dropval());
        chk({req, " count"}, int'(cnt), m_count());
        clr_in();
    endtask

    task automatic do_begin(string req); b = 1; tick(req); endtask
    task automatic do_acc(string req, logic w, logic [7:0] a); av = 1; aw = w; aa = a; tick(req); endtask
    task automatic do_probe(string req, logic w, logic [7:0] a); pv = 1; pw = w; pa = a; tick(req); endtask
    task automatic do_evict(string req, logic [7:0] a); ev = 1; ea = a; tick(req); endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_rd[i] = 0; m_wr[i] = 0; m_tag[i] = 0; end
        clr_in();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 active", int'(act), 0);
        chk("R1 abort", int'(abt), 0);
        chk("R1 cause", int'(cause), 0);
        chk("R1 count", int'(cnt), 0);
        chk("R1 drop", int'(drop), 0);
        rst_n = 1;
        @(negedge clk);

        // R3 idle activity has no effect
        do_acc("R3", 1, 8'h13);
        do_acc("R3", 0, 8'h14);
        do_probe("R3", 1, 8'h13);
        do_evict("R3", 8'h13);
        chk("R3 idle count", int'(cnt), 0);
        do_begin("R3");
        do_probe("R3", 1, 8'h13);
        chk("R3 no abort after idle store", int'(abt), 0);
        do_begin("R3 nested begin ignored");
        chk("R3 still active", int'(act), 1);

        // R2 set bits, R5 read-only not conflicting
        do_acc("R2", 0, 8'h21);
        do_acc("R2", 1, 8'h35);
        chk("R2 count", int'(cnt), 2);
        do_probe("R5 read of read line", 0, 8'h21);
        chk("R5 no conflict", int'(abt), 0);
        do_probe("R5 read of written line", 0, 8'h35);
        chk("R5 abort", int'(abt), 1);
        chk("R5 cause", int'(cause), 1);
        chk("R8 drop mask", int'(drop), 32'h20);
        chk("R8 count cleared", int'(cnt), 0);
        do_acc("R11 after abort", 1, 8'h40);
        chk("R11 pulse over", int'(abt), 0);
        chk("R9 cause held", int'(cause), 1);
        chk("R11 ignored", int'(cnt), 0);

        // R4 write probe hits read line
        do_begin("R9");
        chk("R9 cause cleared", int'(cause), 0);
        do_acc("R4", 0, 8'h12);
        do_probe("R4", 1, 8'h12);
        chk("R4 cause", int'(cause), 1);
        chk("R8 no written lines", int'(drop), 0);

        // R6 overflow by eviction and by aliasing access
        do_begin("R6");
        do_acc("R6", 1, 8'h07);
        do_evict("R6 evict", 8'h07);
        chk("R6 evict cause", int'(cause), 2);
        do_begin("R6");
        do_acc("R6", 0, 8'h18);
        do_evict("R6 other tag", 8'h28);
        chk("R6 unrelated evict", int'(abt), 0);
        do_acc("R6 alias", 0, 8'h28);
        chk("R6 alias abort", int'(abt), 1);
        chk("R6 alias cause", int'(cause), 2);

        // R7 commit
        do_begin("R7");
        do_acc("R7", 1, 8'h18);
        do_acc("R7", 0, 8'h19);
        c = 1;
        tick("R7 commit");
        chk("R7 count", int'(cnt), 0);
        chk("R7 no abort", int'(abt), 0);
        chk("R7 ended", int'(act), 0);
        do_probe("R7 after commit", 1, 8'h18);
        chk("R7 later probe", int'(abt), 0);

        // R10 same-cycle priorities
        do_begin("R10");
        do_acc("R10", 1, 8'h33);
        c = 1; pv = 1; pw = 0; pa = 8'h33;
        tick("R10 commit+probe");
        chk("R10 abort", int'(abt), 1);
        chk("R10 cause", int'(cause), 1);
        do_begin("R10");
        do_acc("R10", 0, 8'h44);
        do_acc("R10", 1, 8'h55);
        pv = 1; pw = 1; pa = 8'h44; ev = 1; ea = 8'h55;
        tick("R10 conflict+overflow");
        chk("R10 conflict wins", int'(cause), 1);
        chk("R8 drop written", int'(drop), 32'h20);

        // randomized traffic against the reference (R2 R4 R5 R6)
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            b  = (r < 8);
            c  = (r >= 8 && r < 11);
            av = ($urandom_range(0, 99) < 50);
            aw = $urandom_range(0, 1) == 1;
            aa = {2'b00, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom_range(0, 3))};
            ev = ($urandom_range(0, 99) < 5);
            ea = {2'b00, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom_range(0, 3))};
            pv = ($urandom_range(0, 99) < 8);
            pw = $urandom_range(0, 1) == 1;
            pa = {2'b00, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom_range(0, 3))};
            tick("R2 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule